// File: doc/BRIEF.md
# SRAM Bank Remap and Byte-Parity Controller

This block sits between a simple single-beat memory bus and five on-chip SRAM banks. It decodes each request address into a bank and a word offset, and it keeps one even-parity bit beside every stored byte. A 32-bit control register does two jobs. Its top bit places one 16 kB bank either in the instruction window or in the data window. Four further bits turn parity checking on or off for the banks that have it. A parity mismatch, an address that hits no bank, or a badly formed transfer ends in a bus error response.

Every request is accepted in the cycle it is presented, and its response appears exactly one cycle later. Byte and halfword writes are done as read-modify-write. The target word is read, all four of its byte parities are checked, and the merged word is then written with fresh parity. A full-word write simply replaces the data and all four parity bits. A test hook can invert one stored parity bit so that the error path can be exercised.

Top module: `sram_remap_parity`

## Requirements
- R1: The control register resets to 0x80000000. Only bit 31 (remap) and bits 21:18 (parity enables) can be written. All other bits read as zero and ignore writes. The register holds its value while no write occurs.
- R2: With bit 31 set, the remappable bank (bank 2) answers at 0x10000000–0x10003FFF, and an access to 0x20004000–0x20007FFF gets a bus error.
- R3: With bit 31 clear, bank 2 answers at 0x20004000–0x20007FFF and holds the same contents, and an access to 0x10000000–0x10003FFF gets a bus error.
- R4: Bank 1 (8 kB) always answers at 0x20002000–0x20003FFF. Banks 3, 4 and 5 (16 kB each) answer at 0x20008000, 0x2000C000 and 0x20010000. Any other address gets a bus error.
- R5: Every request gets exactly one response in the next cycle, and no response appears without a request. An errored response, and every write response, returns read data of zero.
- R6: Control bits 18, 19, 20 and 21 enable parity for banks 2, 3, 4 and 5. Bank 1 never checks parity. A bank whose enable is 0 never reports a parity error.
- R7: A read from a bank with parity enabled errors when any of the four stored byte parities fails to match its data byte under even parity.
- R8: A byte or halfword write to a bank with parity enabled first checks all four byte parities of the target word. On a mismatch it errors and leaves data and parity unchanged.
- R9: A full-word write stores the data and regenerates all four parity bits without checking, which clears any earlier mismatch in that word.
- R10: The size field codes 0 = byte, 1 = halfword, 2 = word and 3 = invalid. Write data sits in its byte lanes, where lane n is bits 8n+7:8n at address low bits n. A partial write replaces only its lanes. A halfword with address bit 0 set, a word with address bits 1:0 non-zero, or size 3 gets a bus error and writes nothing.
- R11: The injection hook inverts the stored parity bit of one lane in one word of one bank (index 0..4 for banks 1..5). Bank indices 5..7 have no effect.
- R12: Each bank stores 2^DEPTH_LOG2 words. Word-offset bits above that depth are ignored, so addresses that differ only in those bits alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register current value |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data in byte lanes |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_err | output | 1 | Bus error on that response |
| resp_rdata | output | 32 | Read data, zero on error or write |
| inj_en | input | 1 | Parity-flip hook strobe |
| inj_bank | input | 3 | Hook bank index (0..4 = banks 1..5) |
| inj_word | input | DEPTH_LOG2 | Hook word index within the bank |
| inj_lane | input | 2 | Hook byte lane |

## Verification
The bench builds the block with its default DEPTH_LOG2 of 6, so each bank stores 64 words. That is small enough to initialise every word of every bank with full-word writes before any read. Random addresses spread over the whole 8 kB or 16 kB windows then alias heavily onto those 64 words. The same words therefore take injections, partial writes, reads and full overwrites in quick succession, and remap and enable changes land on banks that already hold corrupted parity.

// File: rtl/sram_rp_pkg.sv
package sram_rp_pkg;

    localparam int NBANK = 5;
    localparam int BW    = 3;

    localparam logic [31:0] CTL_RESET = 32'h8000_0000;
    localparam logic [31:0] CTL_WMASK = 32'h803C_0000;
    localparam int          REMAP_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef struct packed {
        logic          hit;
        logic [BW-1:0] bank;
        logic [11:0]   woff;
    } dec_t;

    typedef struct packed {
        logic       ok;
        logic [3:0] be;
    } lane_t;

    function automatic logic [3:0] byte_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    // bank index 0..4 stands for banks 1..5
    function automatic dec_t decode(input logic [31:0] a, input logic remap);
        dec_t d;
        d      = '0;
        d.woff = a[13:2];
        if (a[31:13] == 19'h10001) begin
            d.hit  = 1'b1;
            d.bank = 3'd0;
            d.woff = {1'b0, a[12:2]};
        end else if (remap && a[31:14] == 18'h04000) begin
            d.hit  = 1'b1;
            d.bank = 3'd1;
        end else if (!remap && a[31:14] == 18'h08001) begin
            d.hit  = 1'b1;
            d.bank = 3'd1;
        end else if (a[31:14] == 18'h08002) begin
            d.hit  = 1'b1;
            d.bank = 3'd2;
        end else if (a[31:14] == 18'h08003) begin
            d.hit  = 1'b1;
            d.bank = 3'd3;
        end else if (a[31:14] == 18'h08004) begin
            d.hit  = 1'b1;
            d.bank = 3'd4;
        end
        return d;
    endfunction

    function automatic lane_t lanes(input logic [1:0] sz, input logic [1:0] lo);
        lane_t l;
        l = '0;
        case (size_e'(sz))
            SZ_BYTE: begin l.ok = 1'b1;          l.be = 4'b0001 << lo;              end
            SZ_HALF: begin l.ok = !lo[0];        l.be = lo[1] ? 4'b1100 : 4'b0011;  end
            SZ_WORD: begin l.ok = (lo == 2'b00); l.be = 4'b1111;                    end
            default: l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sram_rp_ctl.sv
module sram_rp_ctl
    import sram_rp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= CTL_RESET;
        else if (we) q <= wdata & CTL_WMASK;
    end

    AST_CTL_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> q == CTL_RESET);                                   // R1
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));                                              // R1

endmodule

// File: rtl/sram_rp_bank.sv
module sram_rp_bank #(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [DEPTH_LOG2-1:0] idx,
    input  logic [31:0]           wr_data,
    input  logic [3:0]            wr_par,
    output logic [31:0]           rd_data,
    output logic [3:0]            rd_par,
    input  logic                  inj_en,
    input  logic [DEPTH_LOG2-1:0] inj_idx,
    input  logic [1:0]            inj_lane
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [31:0] mem [DEPTH];
    logic [3:0]  par [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
            par[idx] <= wr_par;
        end
        if (inj_en) par[inj_idx][inj_lane] <= ~par[inj_idx][inj_lane];
    end

    assign rd_data = mem[idx];
    assign rd_par  = par[idx];

endmodule

// File: rtl/sram_remap_parity.sv
module sram_remap_parity
    import sram_rp_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_we,
    input  logic [31:0]           ctl_wdata,
    output logic [31:0]           ctl_rdata,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [31:0]           req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  resp_valid,
    output logic                  resp_err,
    output logic [31:0]           resp_rdata,
    input  logic                  inj_en,
    input  logic [BW-1:0]         inj_bank,
    input  logic [DEPTH_LOG2-1:0] inj_word,
    input  logic [1:0]            inj_lane
);

    logic [31:0] ctl_q;
    dec_t        dec;
    lane_t       ln;
    logic [DEPTH_LOG2-1:0] idx;
    logic        unused_hi;
    logic [31:0] rd_data [NBANK];
    logic [3:0]  rd_par  [NBANK];
    logic [31:0] cur_d, merged;
    logic [3:0]  cur_p;
    logic [7:0]  pen_vec;
    logic        pen, perr, partial, err_now, do_wr;

    sram_rp_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .q     (ctl_q)
    );
    assign ctl_rdata = ctl_q;

    always_comb begin
        dec = decode(req_addr, ctl_q[REMAP_BIT]);
        ln  = lanes(req_size, req_addr[1:0]);
    end
    assign idx       = dec.woff[DEPTH_LOG2-1:0];
    assign unused_hi = ^dec.woff[11:DEPTH_LOG2];

    always_comb begin
        cur_d = '0;
        cur_p = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (dec.bank == BW'(b)) begin
                cur_d = rd_data[b];
                cur_p = rd_par[b];
            end
        end
        for (int i = 0; i < 4; i++)
            merged[8*i +: 8] = ln.be[i] ? req_wdata[8*i +: 8] : cur_d[8*i +: 8];
    end

    assign pen_vec = {3'b000, ctl_q[21:18], 1'b0};
    assign pen     = pen_vec[dec.bank];
    assign perr    = pen && (cur_p != byte_par(cur_d));
    assign partial = (ln.be != 4'hF);
    assign err_now = !dec.hit || !ln.ok || ((!req_write || partial) && perr);
    assign do_wr   = req_valid && req_write && !err_now;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sram_rp_bank #(.DEPTH_LOG2(DEPTH_LOG2)) u_bank (
            .clk      (clk),
            .wr_en    (do_wr && dec.bank == BW'(b)),
            .idx      (idx),
            .wr_data  (merged),
            .wr_par   (byte_par(merged)),
            .rd_data  (rd_data[b]),
            .rd_par   (rd_par[b]),
            .inj_en   (inj_en && inj_bank == BW'(b)),
            .inj_idx  (inj_word),
            .inj_lane (inj_lane)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && err_now;
            resp_rdata <= (req_valid && !req_write && !err_now) ? cur_d : '0;
        end
    end

    AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);                                        // R5
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);                                      // R5
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> resp_rdata == 32'h0);                                // R5
    AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (rst)
        req_valid && !dec.hit |=> resp_err);                              // R4
    AST_PARITY_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_valid && dec.hit && ln.ok && !pen |=> !resp_err);             // R6

endmodule

// File: tb/sram_remap_parity_bench.sv
`timescale 1ns/1ps
module sram_remap_parity_bench;

    localparam int DL = 6;
    localparam int NW = 1 << DL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic        inj_en = 1'b0;
    logic [2:0]  inj_bank = '0;
    logic [DL-1:0] inj_word = '0;
    logic [1:0]  inj_lane = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] mctl;
    logic [31:0] md [5][NW];
    logic [3:0]  mp [5][NW];

    always #2 clk = ~clk;

    sram_remap_parity #(.DEPTH_LOG2(DL)) u_sram_remap_parity (
        .clk, .rst, .ctl_we, .ctl_wdata, .ctl_rdata,
        .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
        .resp_valid, .resp_err, .resp_rdata,
        .inj_en, .inj_bank, .inj_word, .inj_lane
    );

    function automatic logic [3:0] gp(input logic [31:0] d);
        return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
    endfunction

    function automatic logic [31:0] bbase(input int b, input bit remap);
        if (b == 0) return 32'h2000_2000;
        if (b == 1) return remap ? 32'h1000_0000 : 32'h2000_4000;
        return 32'h2000_8000 + 32'(b - 2) * 32'h4000;
    endfunction

    function automatic int bdec(input logic [31:0] a, input bit remap, output int ix);
        int b;
        b = -1;
        ix = 0;
        if (a >= 32'h2000_2000 && a <= 32'h2000_3FFF) b = 0;
        else if (remap && a >= 32'h1000_0000 && a <= 32'h1000_3FFF) b = 1;
        else if (!remap && a >= 32'h2000_4000 && a <= 32'h2000_7FFF) b = 1;
        else if (a >= 32'h2000_8000 && a <= 32'h2001_3FFF) b = 2 + int'((a - 32'h2000_8000) >> 14);
        if (b >= 0) ix = int'(((a - bbase(b, remap)) >> 2) % NW);
        return b;
    endfunction

    task automatic model(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                         input logic [31:0] wd, output bit e, output logic [31:0] rd);
        int b, ix;
        bit ok, en, bad;
        logic [3:0] be;
        logic [31:0] m;
        b  = bdec(a, mctl[31], ix);
        ok = (sz == 2'd0) || (sz == 2'd1 && !a[0]) || (sz == 2'd2 && a[1:0] == 2'b00);
        be = (sz == 2'd0) ? (4'b0001 << a[1:0]) : (sz == 2'd1) ? (a[1] ? 4'hC : 4'h3) : 4'hF;
        e  = 1'b0;
        rd = '0;
        if (b < 0 || !ok) e = 1'b1;
        else begin
            en  = (b > 0) && mctl[17 + b];
            bad = en && (mp[b][ix] != gp(md[b][ix]));
            if (!wr) begin
                if (bad) e = 1'b1; else rd = md[b][ix];
            end else if (be == 4'hF) begin
                md[b][ix] = wd;
                mp[b][ix] = gp(wd);
            end else if (bad) e = 1'b1;
            else begin
                m = md[b][ix];
                for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = wd[8*i +: 8];
                md[b][ix] = m;
                mp[b][ix] = gp(m);
            end
        end
    endtask

    task automatic check(input bit good, input string tag, input string detail);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s", tag, detail);
        end
    endtask

    task automatic bus(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
        bit e;
        logic [31:0] rd;
        model(a, wr, sz, wd, e, rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(resp_valid === 1'b1 && resp_err === e && resp_rdata === rd, tag,
              $sformatf("addr=%h wr=%0d sz=%0d: valid=%b err=%b data=%h expected valid=1 err=%b data=%h",
                        a, wr, sz, resp_valid, resp_err, resp_rdata, e, rd));
    endtask

    task automatic ctl_write(input logic [31:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        mctl = v & 32'h803C_0000;
    endtask

    task automatic inject(input int b, input int w, input int lane);
        @(negedge clk);
        inj_en = 1'b1; inj_bank = 3'(b); inj_word = DL'(w); inj_lane = 2'(lane);
        @(negedge clk);
        inj_en = 1'b0;
        if (b < 5) mp[b][w][lane] = ~mp[b][w][lane];
    endtask

    task automatic ctl_check(input logic [31:0] exp_v, input string tag);
        check(ctl_rdata === exp_v, tag, $sformatf("ctl=%h expected %h", ctl_rdata, exp_v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        mctl = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ctl_check(32'h8000_0000, "R1 reset value");
        check(resp_valid === 1'b0, "R5 idle after reset", $sformatf("valid=%b expected 0", resp_valid));

        // R1 writable and reserved bits
        ctl_write(32'hFFFF_FFFF);
        ctl_check(32'h803C_0000, "R1 reserved bits read zero");
        ctl_write(32'h0000_0000);
        ctl_check(32'h0000_0000, "R1 clear");
        ctl_write(32'h803C_0000);
        ctl_check(32'h803C_0000, "R1 enable all");

        // R9 fill every word of every bank with full-word writes
        for (int b = 0; b < 5; b++)
            for (int w = 0; w < NW; w++)
                bus(bbase(b, 1'b1) + 32'(w * 4), 1'b1, 2'd2, $urandom, "R9 init full write");

        // R2 remap set
        bus(32'h1000_0010, 1'b0, 2'd2, 0, "R2 instruction window read");
        bus(32'h2000_4010, 1'b0, 2'd2, 0, "R2 data window errors");
        // R3 remap clear, same contents
        ctl_write(32'h003C_0000);
        bus(32'h2000_4010, 1'b0, 2'd2, 0, "R3 data window read");
        bus(32'h1000_0010, 1'b0, 2'd2, 0, "R3 instruction window errors");
        // R4 fixed banks and unmapped space
        bus(32'h2000_3FFC, 1'b0, 2'd2, 0, "R4 bank1 top");
        bus(32'h2001_3FFC, 1'b0, 2'd2, 0, "R4 bank5 top");
        bus(32'h2001_4000, 1'b0, 2'd2, 0, "R4 above bank5");
        bus(32'h2000_1FFC, 1'b0, 2'd2, 0, "R4 below bank1");

        // R11 + R7 injection on bank3 word 5 lane 2
        inject(2, 5, 2);
        bus(32'h2000_8014, 1'b0, 2'd2, 0, "R7 read after injection");
        bus(32'h2000_8014, 1'b1, 2'd0, 32'hAAAA_AAAA, "R8 byte write blocked");
        ctl_write(32'h0034_0000);
        bus(32'h2000_8014, 1'b0, 2'd2, 0, "R8 R6 unchanged data with parity off");
        ctl_write(32'h003C_0000);
        bus(32'h2000_8014, 1'b0, 2'd2, 0, "R7 still errors");
        bus(32'h2000_8014, 1'b1, 2'd2, 32'h1234_5678, "R9 full write clears");
        bus(32'h2000_8014, 1'b0, 2'd2, 0, "R9 read after clear");
        // R6 bank1 never checks
        inject(0, 7, 1);
        bus(32'h2000_201C, 1'b0, 2'd2, 0, "R6 bank1 ignores parity");
        // R11 out-of-range bank index
        inject(6, 3, 0);
        bus(32'h2000_C00C, 1'b0, 2'd2, 0, "R11 bank index 6 ignored");
        // R10 merge, misalignment, bad size
        bus(32'h2000_C022, 1'b1, 2'd1, 32'hBEEF_0000, "R10 upper halfword write");
        bus(32'h2000_C023, 1'b1, 2'd0, 32'h5A00_0000, "R10 byte lane 3 write");
        bus(32'h2000_C020, 1'b0, 2'd2, 0, "R10 merged read");
        bus(32'h2000_C021, 1'b1, 2'd1, 32'hFFFF_FFFF, "R10 misaligned halfword");
        bus(32'h2000_C022, 1'b0, 2'd2, 0, "R10 misaligned word read");
        bus(32'h2000_C020, 1'b1, 2'd3, 32'hFFFF_FFFF, "R10 size 3");
        bus(32'h2000_C020, 1'b0, 2'd2, 0, "R10 unchanged after rejected writes");
        // R12 aliasing above stored depth
        bus(32'h2001_000C + 32'(NW * 4), 1'b1, 2'd2, 32'hC0DE_0001, "R12 write alias");
        bus(32'h2001_000C, 1'b0, 2'd2, 0, "R12 read base word");

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int k, b, w, nw;
            logic [1:0] sz, lo;
            logic [31:0] a;
            k = $urandom_range(0, 99);
            if (k < 4) ctl_write($urandom);
            else if (k < 10) inject($urandom_range(0, 4), $urandom_range(0, NW - 1), $urandom_range(0, 3));
            else begin
                b  = $urandom_range(0, 4);
                nw = (b == 0) ? 2048 : 4096;
                w  = $urandom_range(0, nw - 1);
                sz = 2'($urandom_range(0, 3));
                lo = ($urandom_range(0, 9) < 8) ? ((sz == 2'd0) ? 2'($urandom_range(0, 3)) :
                                                   (sz == 2'd1) ? {1'($urandom_range(0, 1)), 1'b0} : 2'b00)
                                                : 2'($urandom_range(0, 3));
                a = bbase(b, mctl[31]) + 32'(w * 4) + 32'(lo);
                if (k < 14) a = 32'h3000_0000 + 32'($urandom_range(0, 65535));
                else if (k < 18 && b == 1) a = bbase(1, !mctl[31]) + 32'(w * 4);
                bus(a, 1'($urandom_range(0, 1)), sz, $urandom, "R2 R3 R7 R8 R9 R10 random");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule